// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block sits between the interrupt request flags of a small microcontroller and its instruction fetch unit. It sorts sources into thirty-two fixed slots. Several peripheral flags may be ORed into one slot before they reach the block. Each slot belongs to one of three classes. The top slot is the reset class and can never be masked. The slot below it is the non-maskable class: its own enable can block it, but the global enable cannot. Every other slot is maskable and needs both its own enable and the global enable.

On each clock edge the controller finds the highest-numbered eligible slot. When the CPU asserts `accept_i`, the controller registers the matching handler-pointer address and raises a one-hot acknowledge strobe for that slot, which the flag logic uses to clear single-source flags. Handler pointers sit in the top 64 bytes of the 16-bit address space. Slot `s` maps to address `0xFFC0 + 2*s`, so slot 31 maps to 0xFFFE and slot 30 maps to 0xFFFC.

The block also checks the word fetched from the reset pointer. If every bit of that word is set, the memory is unprogrammed and the block raises a flag that tells the power controller to drop into the deepest sleep mode instead of starting execution.

Top module: `irq_vector_ctrl`

## Requirements
- R1: While `rst_n` is low and on the first edge after it is released, `vec_addr_o` is 0xFFFE and `ack_o`, `pend_o` and `blank_rst_o` are all 0.
- R2: After a grant of slot s, `vec_addr_o` reads 0xFFC0 + 2*s one cycle later. Without a grant it keeps its value.
- R3: When several slots are eligible, the highest-numbered one is granted, for example slot 27 over slot 26 and slot 24.
- R4: A slot from 0 to 29 is eligible only when its `req_i` bit, its `ien_i` bit and `gie_i` are all 1.
- R5: Slot 30 is eligible when `req_i[30]` and `ien_i[30]` are both 1, whatever the value of `gie_i`.
- R6: Slot 31 is eligible whenever `req_i[31]` is 1. Neither `gie_i` nor any enable affects it, and it beats all other slots.
- R7: `ack_o` is one-hot at bit s one cycle after an edge with `accept_i`=1 and slot s granted. In every other case it is 0.
- R8: `pend_o` is 1 one cycle after an edge at which at least one slot is eligible, whether or not `accept_i` is set.
- R9: At an edge with `fetch_valid_i`=1, `blank_rst_o` becomes 1 if `fetch_word_i` is 0xFFFF and 0 for any other word. It holds its value while `fetch_valid_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 32 | Per-slot request flags, already ORed across shared sources |
| ien_i | input | 31 | Per-slot enables for slots 0 to 30 (slot 31 has none) |
| gie_i | input | 1 | Global enable for the maskable slots |
| accept_i | input | 1 | CPU takes an interrupt at this edge if one is eligible |
| fetch_valid_i | input | 1 | `fetch_word_i` holds the reset pointer word |
| fetch_word_i | input | 16 | Word fetched from the reset pointer |
| vec_addr_o | output | 16 | Pointer address of the last granted slot |
| ack_o | output | 32 | One-cycle one-hot acknowledge of the granted slot |
| pend_o | output | 1 | At least one slot was eligible at the last edge |
| blank_rst_o | output | 1 | Last fetched reset pointer was blank |

## Verification
The assertions assume that `rst_n` starts low and is released only once. They also assume that all inputs change only between clock edges, and that `fetch_word_i` matters only in cycles where `fetch_valid_i` is high. The stimulus drives every input at the falling edge. It holds reset for several cycles at the start. It mixes fully random request, enable and fetch patterns with directed cases that isolate each slot class with the global enable on and off. Blank and non-blank pointer words are presented both with and without the fetch strobe.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

    typedef enum logic [1:0] {
        CLS_MASKABLE = 2'd0,
        CLS_NONMASK  = 2'd1,
        CLS_RESET    = 2'd2
    } slot_class_e;

    // The top slot is reset class, the next is non-maskable, the rest are maskable.
    function automatic slot_class_e class_of(input int slot, input int num_slots);
        if (slot == num_slots - 1)      return CLS_RESET;
        else if (slot == num_slots - 2) return CLS_NONMASK;
        else                            return CLS_MASKABLE;
    endfunction

endpackage

// File: rtl/ivc_elig.sv
module ivc_elig #(
    parameter int NUM_SLOTS = 32
) (
    input  logic [NUM_SLOTS-1:0] req_i,
    input  logic [NUM_SLOTS-2:0] ien_i,
    input  logic                 gie_i,
    output logic [NUM_SLOTS-1:0] elig_o
);
    import ivc_pkg::*;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        if (class_of(g, NUM_SLOTS) == CLS_RESET) begin : g_rst
            assign elig_o[g] = req_i[g];
        end else if (class_of(g, NUM_SLOTS) == CLS_NONMASK) begin : g_nmi
            assign elig_o[g] = req_i[g] & ien_i[g];
        end else begin : g_mask
            assign elig_o[g] = req_i[g] & ien_i[g] & gie_i;
        end
    end

endmodule

// File: rtl/ivc_prio.sv
module ivc_prio #(
    parameter int NUM_SLOTS = 32,
    localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
    input  logic [NUM_SLOTS-1:0] elig_i,
    output logic                 any_o,
    output logic [IDX_W-1:0]     idx_o
);
    // The scan runs upward, so a higher eligible slot overrides a lower one.
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (elig_i[i]) begin
                any_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/ivc_blank.sv
module ivc_blank #(
    parameter int WORD_W = 16
) (
    input  logic [WORD_W-1:0] word_i,
    output logic              blank_o
);
    // Erased memory reads as all ones.
    assign blank_o = &word_i;

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
    parameter int                 NUM_SLOTS = 32,
    parameter int                 ADDR_W    = 16,
    parameter logic [ADDR_W-1:0]  VEC_BASE  = 16'hFFC0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SLOTS-1:0] req_i,
    input  logic [NUM_SLOTS-2:0] ien_i,
    input  logic                 gie_i,
    input  logic                 accept_i,
    input  logic                 fetch_valid_i,
    input  logic [ADDR_W-1:0]    fetch_word_i,
    output logic [ADDR_W-1:0]    vec_addr_o,
    output logic [NUM_SLOTS-1:0] ack_o,
    output logic                 pend_o,
    output logic                 blank_rst_o
);
    localparam int               IDX_W   = $clog2(NUM_SLOTS);
    localparam int               PAD_W   = ADDR_W - IDX_W - 1;
    localparam logic [ADDR_W-1:0] RST_VEC = VEC_BASE + ADDR_W'(2 * (NUM_SLOTS - 1));

    typedef struct packed {
        logic [ADDR_W-1:0]    vec;
        logic [NUM_SLOTS-1:0] ack;
        logic                 pend;
        logic                 blank;
    } state_t;

    state_t state_d, state_q;

    logic [NUM_SLOTS-1:0] elig;
    logic                 any_elig;
    logic [IDX_W-1:0]     win_idx;
    logic                 word_blank;

    ivc_elig #(.NUM_SLOTS(NUM_SLOTS)) elig_i (
        .req_i  (req_i),
        .ien_i  (ien_i),
        .gie_i  (gie_i),
        .elig_o (elig)
    );

    ivc_prio #(.NUM_SLOTS(NUM_SLOTS)) prio_i (
        .elig_i (elig),
        .any_o  (any_elig),
        .idx_o  (win_idx)
    );

    ivc_blank #(.WORD_W(ADDR_W)) blank_i (
        .word_i  (fetch_word_i),
        .blank_o (word_blank)
    );

    always_comb begin
        state_d      = state_q;
        state_d.ack  = '0;
        state_d.pend = any_elig;
        if (accept_i && any_elig) begin
            state_d.vec          = VEC_BASE + {{PAD_W{1'b0}}, win_idx, 1'b0};
            state_d.ack[win_idx] = 1'b1;
        end
        if (fetch_valid_i) begin
            state_d.blank = word_blank;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.vec   <= RST_VEC;
            state_q.ack   <= '0;
            state_q.pend  <= 1'b0;
            state_q.blank <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign vec_addr_o  = state_q.vec;
    assign ack_o       = state_q.ack;
    assign pend_o      = state_q.pend;
    assign blank_rst_o = state_q.blank;

endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
    parameter int                NUM_SLOTS = 32,
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] VEC_BASE  = 16'hFFC0
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_SLOTS-1:0] req_i,
    input logic                 gie_i,
    input logic                 accept_i,
    input logic                 fetch_valid_i,
    input logic [ADDR_W-1:0]    fetch_word_i,
    input logic [ADDR_W-1:0]    vec_addr_o,
    input logic [NUM_SLOTS-1:0] ack_o,
    input logic                 pend_o,
    input logic                 blank_rst_o
);
    // Set from the second edge after reset, so that $past never reaches into reset.
    logic armed_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    p_ack_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_o));

    p_ack_implies_pend_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|ack_o) |-> pend_o);

    p_vec_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && !(|ack_o) |-> $stable(vec_addr_o));

    p_vec_region_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_addr_o[0] == 1'b0) && (vec_addr_o >= VEC_BASE));

    p_reset_slot_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(req_i[NUM_SLOTS-1]) && $past(accept_i) |-> ack_o[NUM_SLOTS-1]);

    p_gie_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(!gie_i) && (|ack_o) |-> (ack_o[NUM_SLOTS-1] || ack_o[NUM_SLOTS-2]));

    p_blank_update_r9: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(fetch_valid_i) |-> (blank_rst_o == ($past(fetch_word_i) == '1)));

    p_blank_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(!fetch_valid_i) |-> $stable(blank_rst_o));

endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(
    .NUM_SLOTS (NUM_SLOTS),
    .ADDR_W    (ADDR_W),
    .VEC_BASE  (VEC_BASE)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_i         (req_i),
    .gie_i         (gie_i),
    .accept_i      (accept_i),
    .fetch_valid_i (fetch_valid_i),
    .fetch_word_i  (fetch_word_i),
    .vec_addr_o    (vec_addr_o),
    .ack_o         (ack_o),
    .pend_o        (pend_o),
    .blank_rst_o   (blank_rst_o)
);

// File: tb/irq_vector_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_vector_ctrl_tb_top;
    localparam int N = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  req_i = '0;
    logic [N-2:0]  ien_i = '0;
    logic          gie_i = 1'b0;
    logic          accept_i = 1'b0;
    logic          fetch_valid_i = 1'b0;
    logic [15:0]   fetch_word_i = '0;
    logic [15:0]   vec_addr_o;
    logic [N-1:0]  ack_o;
    logic          pend_o;
    logic          blank_rst_o;

    int n_tests = 0;
    int n_fail  = 0;

    logic [15:0]  exp_vec   = 16'hFFFE;
    logic         exp_blank = 1'b0;

    always #2.5 clk = ~clk;

    irq_vector_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .ien_i(ien_i), .gie_i(gie_i),
        .accept_i(accept_i), .fetch_valid_i(fetch_valid_i), .fetch_word_i(fetch_word_i),
        .vec_addr_o(vec_addr_o), .ack_o(ack_o), .pend_o(pend_o), .blank_rst_o(blank_rst_o)
    );

    function automatic logic [N-1:0] model_elig(logic [N-1:0] r, logic [N-2:0] e, logic g);
        logic [N-1:0] m;
        for (int i = 0; i < N - 2; i++) m[i] = r[i] & e[i] & g;
        m[N-2] = r[N-2] & e[N-2];
        m[N-1] = r[N-1];
        return m;
    endfunction

    function automatic int model_top(logic [N-1:0] m);
        int s = -1;
        for (int i = 0; i < N; i++) if (m[i]) s = i;
        return s;
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Drive at the falling edge, let one rising edge pass, compare at the next falling edge.
    task automatic step(string tag, logic [N-1:0] r, logic [N-2:0] e, logic g, logic acc,
                        logic fv, logic [15:0] fw);
        int s;
        logic [N-1:0] eack;
        req_i = r; ien_i = e; gie_i = g; accept_i = acc;
        fetch_valid_i = fv; fetch_word_i = fw;
        s = model_top(model_elig(r, e, g));
        eack = '0;
        if (acc && s >= 0) begin
            eack[s] = 1'b1;
            exp_vec = 16'hFFC0 + 16'(2 * s);
        end
        if (fv) exp_blank = (fw == 16'hFFFF);
        @(negedge clk);
        chk({tag, " vec"},   64'(vec_addr_o),  64'(exp_vec));
        chk({tag, " ack"},   64'(ack_o),       64'(eack));
        chk({tag, " pend"},  64'(pend_o),      64'(s >= 0));
        chk({tag, " blank"}, 64'(blank_rst_o), 64'(exp_blank));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        logic [N-1:0] r;
        logic [N-2:0] e;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1: reset values while reset is held
        chk("R1 vec",   64'(vec_addr_o),  64'hFFFE);
        chk("R1 ack",   64'(ack_o),       64'h0);
        chk("R1 pend",  64'(pend_o),      64'h0);
        chk("R1 blank", 64'(blank_rst_o), 64'h0);
        rst_n = 1'b1;
        step("R1 idle", '0, '0, 1'b0, 1'b0, 1'b0, 16'h0);

        // R2/R4: lowest slot alone with everything enabled
        step("R2 slot0", 32'h1, '1, 1'b1, 1'b1, 1'b0, 16'h0);
        // R4: global enable off blocks a maskable slot
        step("R4 gie off", 32'h20, '1, 1'b0, 1'b1, 1'b0, 16'h0);
        // R4: own enable off blocks a maskable slot
        step("R4 ien off", 32'h20, ~31'h20, 1'b1, 1'b1, 1'b0, 16'h0);
        // R5: slot 30 ignores gie
        step("R5 nmi gie off", 32'h4000_0000, 31'h4000_0000, 1'b0, 1'b1, 1'b0, 16'h0);
        // R5: slot 30 blocked by its own enable
        step("R5 nmi ien off", 32'h4000_0001, 31'h1, 1'b0, 1'b1, 1'b0, 16'h0);
        // R6: slot 31 with nothing enabled wins over slot 30
        step("R6 reset", 32'hC000_0000, '0, 1'b0, 1'b1, 1'b0, 16'h0);
        step("R6 reset over nmi", 32'hC000_0000, '1, 1'b1, 1'b1, 1'b0, 16'h0);
        // R3: slot 27 over 26 and 24
        step("R3 27 over 26", 32'h0D00_0000, '1, 1'b1, 1'b1, 1'b0, 16'h0);
        step("R3 26 over 24", 32'h0500_0000, '1, 1'b1, 1'b1, 1'b0, 16'h0);
        // R7/R8: no accept, pend set, ack zero, vec held
        step("R7 no accept", 32'h0100_0000, '1, 1'b1, 1'b0, 1'b0, 16'h0);
        // R9: blank word, hold, non-blank word
        step("R9 blank", '0, '0, 1'b0, 1'b0, 1'b1, 16'hFFFF);
        step("R9 hold", '0, '0, 1'b0, 1'b0, 1'b0, 16'h1234);
        step("R9 clear", '0, '0, 1'b0, 1'b0, 1'b1, 16'hFFFE);
        step("R9 hold ffff", '0, '0, 1'b0, 1'b0, 1'b0, 16'hFFFF);

        // R3: random mix of requests, enables and fetch words
        for (int k = 0; k < 3000; k++) begin
            r = $urandom() & $urandom();
            if ($urandom_range(3) == 0) r[N-1] = 1'b0;
            if ($urandom_range(1) == 0) r[N-1] = 1'b0;
            e = 31'($urandom());
            step("R3 random", r, e, 1'($urandom()), 1'($urandom()),
                 1'($urandom_range(3) == 0),
                 ($urandom_range(1) == 0) ? 16'hFFFF : 16'($urandom()));
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule